// File: doc/BRIEF.md
# Rectangular Block-Copy Address Sequencer

This block walks a rectangular image and produces, one pair per clock, the source and destination byte addresses for a 16-bit element copy. The image is stored packed at the source. It is placed into a frame buffer whose rows are a fixed number of pixels apart. A controller supplies both base addresses, the image size in pixels, the target column and row, and the bytes per pixel, then pulses a start input. The block emits the pairs through a valid/ready handshake and signals completion with a single-cycle done pulse.

The source is read as one linear stream with a 2-byte step. The destination steps by 2 bytes within a row. At each row end, a single precomputed row-modify step both moves to the next frame-buffer line and accounts for the element size. The target column is always rounded down to an even pixel. A row byte count that is odd cannot be covered by 16-bit elements, so such a request is refused with an error pulse.

Top module: `blit_addr_gen`

## Requirements
- R1: While reset is applied and after its release, `pair_valid_o`, `busy_o`, `done_o` and `err_o` are low until a start is accepted.
- R2: The first destination address equals dst_base + (pos_x with bit 0 cleared) × bpp + pos_y × FB_COLS × bpp.
- R3: The first source address equals src_base, and the first pair is valid in the cycle after the clock edge that accepts the start.
- R4: A transfer emits exactly height × (width × bpp / 2) pairs, and `busy_o` and `pair_valid_o` are high from the first pair until the last pair is accepted.
- R5: Within a row, each accepted pair advances both the source and the destination address by 2.
- R6: After the last element of a row is accepted, the destination advances by (FB_COLS − width) × bpp + 2, and the source advances by 2.
- R7: While `pair_valid_o` is high and `pair_ready_i` is low, the valid signal and both addresses hold.
- R8: `pair_last_o` is high only on the final pair, and `done_o` is high for exactly the one cycle after that pair is accepted.
- R9: A start pulse while a transfer is active is ignored: the sequence continues unchanged and `err_o` stays low.
- R10: A start with width × bpp odd raises `err_o` for one cycle, emits no pair and leaves `busy_o` low.
- R11: A start with zero width, zero height or zero bpp (and an even row byte count) emits no pair and raises `done_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| src_base_i | input | AW | Source byte base address |
| dst_base_i | input | AW | Frame-buffer byte base address |
| width_i | input | DW | Image width in pixels |
| height_i | input | DW | Image height in pixels |
| pos_x_i | input | DW | Target column (rounded down to even) |
| pos_y_i | input | DW | Target row |
| bpp_i | input | BW | Bytes per pixel |
| pair_valid_o | output | 1 | Address pair is valid |
| pair_ready_i | input | 1 | Consumer accepts the pair |
| src_addr_o | output | AW | Source byte address |
| dst_addr_o | output | AW | Destination byte address |
| pair_last_o | output | 1 | Current pair is the last of the transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a refused odd-size start |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 12-bit dimensions, 3-bit bytes per pixel and a 320-pixel frame-buffer stride. With the real stride in place, the expected destination values carry the true line pitch. Small images of one to nine pixels keep every run short while still covering several row wraps, one-element rows, an odd target column and a centred placement. Three ready patterns (always, alternate, one in three) exercise the hold behaviour. Each clock, the bench compares the outputs against a pair index that it computes independently.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int unsigned ELEM_BYTES = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_st_e;

endpackage

// File: rtl/blit_setup.sv
module blit_setup
  import blit_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 12,
  parameter int BW      = 3,
  parameter int FB_COLS = 320,
  localparam int EW     = DW + BW
) (
  input  logic [AW-1:0] dst_base_i,
  input  logic [DW-1:0] width_i,
  input  logic [DW-1:0] height_i,
  input  logic [DW-1:0] pos_x_i,
  input  logic [DW-1:0] pos_y_i,
  input  logic [BW-1:0] bpp_i,
  output logic [AW-1:0] dst_start_o,
  output logic [AW-1:0] row_mod_o,
  output logic [EW-1:0] elems_o,
  output logic          odd_o,
  output logic          empty_o
);

  localparam logic [AW-1:0] COLS_A = AW'(FB_COLS);

  logic [EW-1:0] bytes_row;
  logic [AW-1:0] bpp_a;
  logic [AW-1:0] x_even;

  always_comb begin
    bytes_row   = EW'(width_i) * EW'(bpp_i);
    bpp_a       = AW'(bpp_i);
    x_even      = AW'(pos_x_i) & ~AW'(1);
    elems_o     = bytes_row >> 1;
    odd_o       = bytes_row[0];
    empty_o     = (bytes_row == '0) || (height_i == '0);
    dst_start_o = dst_base_i + x_even * bpp_a + AW'(pos_y_i) * COLS_A * bpp_a;
    row_mod_o   = COLS_A * bpp_a - AW'(bytes_row) + AW'(ELEM_BYTES);
  end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 12,
  parameter int EW  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          odd_i,
  input  logic          empty_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_start_i,
  input  logic [AW-1:0] row_mod_i,
  input  logic [EW-1:0] elems_i,
  input  logic [DW-1:0] height_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          last_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  walk_st_e      state_q, state_d;
  logic          done_q, done_d, err_q, err_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d, rowmod_q, rowmod_d;
  logic [EW-1:0] col_q, col_d, elems_q, elems_d;
  logic [DW-1:0] row_q, row_d, rows_q, rows_d;
  logic          take, fire, row_end, last, data_en;

  always_comb begin
    take    = start_i && (state_q == ST_IDLE);
    fire    = (state_q == ST_RUN) && ready_i;
    row_end = (col_q == elems_q - EW'(1));
    last    = row_end && (row_q == rows_q - DW'(1));
    data_en = take || fire;
    state_d  = state_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    src_d    = src_q;
    dst_d    = dst_q;
    col_d    = col_q;
    row_d    = row_q;
    elems_d  = elems_q;
    rows_d   = rows_q;
    rowmod_d = rowmod_q;
    if (take) begin
      if (odd_i) begin
        err_d = 1'b1;
      end else if (empty_i) begin
        done_d = 1'b1;
      end else begin
        state_d  = ST_RUN;
        src_d    = src_base_i;
        dst_d    = dst_start_i;
        col_d    = '0;
        row_d    = '0;
        elems_d  = elems_i;
        rows_d   = height_i;
        rowmod_d = row_mod_i;
      end
    end else if (fire) begin
      src_d = src_q + AW'(ELEM_BYTES);
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else if (row_end) begin
        col_d = '0;
        row_d = row_q + DW'(1);
        dst_d = dst_q + rowmod_q;
      end else begin
        col_d = col_q + EW'(1);
        dst_d = dst_q + AW'(ELEM_BYTES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      src_q    <= src_d;
      dst_q    <= dst_d;
      col_q    <= col_d;
      row_q    <= row_d;
      elems_q  <= elems_d;
      rows_q   <= rows_d;
      rowmod_q <= rowmod_d;
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign busy_o  = (state_q == ST_RUN);
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign last_o  = valid_o && last;
  assign done_o  = done_q;
  assign err_o   = err_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !valid_o); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(src_q) && $stable(dst_q)); // R7
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && !last |=> src_q == $past(src_q) + AW'(ELEM_BYTES)); // R5
  AST_DST_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && !row_end |=> dst_q == $past(dst_q) + AW'(ELEM_BYTES)); // R5
  AST_DST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && row_end && !last |=> dst_q == $past(dst_q) + $past(rowmod_q)); // R6
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !valid_o && !busy_o); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && start_i && !(ready_i && last) |=> valid_o && !err_q && !done_q); // R9

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 12,
  parameter int BW      = 3,
  parameter int FB_COLS = 320
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [DW-1:0] width_i,
  input  logic [DW-1:0] height_i,
  input  logic [DW-1:0] pos_x_i,
  input  logic [DW-1:0] pos_y_i,
  input  logic [BW-1:0] bpp_i,
  output logic          pair_valid_o,
  input  logic          pair_ready_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          pair_last_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  localparam int EW = DW + BW;

  logic          rst_meta_q, rst_sync_q;
  logic [AW-1:0] dst_start, row_mod;
  logic [EW-1:0] elems;
  logic          odd, empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  blit_setup #(
    .AW(AW), .DW(DW), .BW(BW), .FB_COLS(FB_COLS)
  ) u_setup (
    .dst_base_i (dst_base_i),
    .width_i    (width_i),
    .height_i   (height_i),
    .pos_x_i    (pos_x_i),
    .pos_y_i    (pos_y_i),
    .bpp_i      (bpp_i),
    .dst_start_o(dst_start),
    .row_mod_o  (row_mod),
    .elems_o    (elems),
    .odd_o      (odd),
    .empty_o    (empty)
  );

  blit_walker #(
    .AW(AW), .DW(DW), .EW(EW)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_i    (start_i),
    .odd_i      (odd),
    .empty_i    (empty),
    .src_base_i (src_base_i),
    .dst_start_i(dst_start),
    .row_mod_i  (row_mod),
    .elems_i    (elems),
    .height_i   (height_i),
    .ready_i    (pair_ready_i),
    .valid_o    (pair_valid_o),
    .src_o      (src_addr_o),
    .dst_o      (dst_addr_o),
    .last_o     (pair_last_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |=> !pair_valid_o && !done_o && !err_o); // R1

endmodule

// File: tb/blit_addr_gen_tb.sv
`timescale 1ns/1ps
module blit_addr_gen_tb;

  localparam int AW = 32, DW = 12, BW = 3, COLS = 320;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] src_base_i, dst_base_i;
  logic [DW-1:0] width_i, height_i, pos_x_i, pos_y_i;
  logic [BW-1:0] bpp_i;
  logic          pair_valid_o, pair_ready_i, pair_last_o, busy_o, done_o, err_o;
  logic [AW-1:0] src_addr_o, dst_addr_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  blit_addr_gen #(.AW(AW), .DW(DW), .BW(BW), .FB_COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i),
    .width_i(width_i), .height_i(height_i), .pos_x_i(pos_x_i), .pos_y_i(pos_y_i),
    .bpp_i(bpp_i), .pair_valid_o(pair_valid_o), .pair_ready_i(pair_ready_i),
    .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .pair_last_o(pair_last_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic set_req(input int sb, input int db, input int w, input int h,
                         input int x, input int y, input int bpp);
    src_base_i = AW'(sb);
    dst_base_i = AW'(db);
    width_i    = DW'(w);
    height_i   = DW'(h);
    pos_x_i    = DW'(x);
    pos_y_i    = DW'(y);
    bpp_i      = BW'(bpp);
  endtask

  // Reference: pair idx maps to row idx/e, column idx%e; addresses from the formulas.
  task automatic run_case(input int sb, input int db, input int w, input int h,
                          input int x, input int y, input int bpp,
                          input int mode, input bit inject);
    int e, n, idx, k, r, c;
    logic ready_d, exp_done, stop;
    longint esrc, edst;
    string rs, rd;
    e = (w * bpp) / 2;
    n = e * h;
    @(negedge clk);
    set_req(sb, db, w, h, x, y, bpp);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idx = 0; k = 0; stop = 1'b0;
    exp_done = (n == 0);                                        // R11
    while (!stop && k < 5000) begin
      chk(pair_valid_o == (idx < n), "R4 valid", pair_valid_o, idx < n);
      chk(busy_o == (idx < n), "R4 busy", busy_o, idx < n);
      chk(done_o == exp_done, "R8 done", done_o, exp_done);
      chk(err_o == 1'b0, "R9 err", err_o, 0);
      if (idx < n && pair_valid_o) begin
        r = idx / e;
        c = idx % e;
        esrc = (longint'(sb) + 2 * idx) & 32'hFFFF_FFFF;
        edst = (longint'(db) + (x & ~1) * bpp + (y + r) * COLS * bpp + 2 * c) & 32'hFFFF_FFFF;
        rs = (idx == 0) ? "R3 src" : (c == 0) ? "R6 src" : "R5 src";
        rd = (idx == 0) ? "R2 dst" : (c == 0) ? "R6 dst" : "R5 dst";
        chk(src_addr_o == AW'(esrc), rs, src_addr_o, esrc);
        chk(dst_addr_o == AW'(edst), rd, dst_addr_o, edst);
        chk(pair_last_o == (idx == n - 1), "R8 last", pair_last_o, idx == n - 1);
      end
      if (exp_done) begin
        stop = 1'b1;
      end else begin
        ready_d = (mode == 0) ? 1'b1 : (mode == 1) ? k[0] : (k % 3 == 2);  // R7 stalls
        pair_ready_i = ready_d;
        if (inject && k == 2) begin
          set_req(32'h5555_0000, 32'h7777_0000, 5, 9, 3, 3, 1);         // R9 busy start
          start_i = 1'b1;
        end else begin
          start_i = 1'b0;
        end
        exp_done = (idx < n) && ready_d && (idx == n - 1);
        if (idx < n && ready_d) idx++;
        k++;
        @(negedge clk);
      end
    end
    chk(stop, "R4 completion", stop, 1);
    pair_ready_i = 1'b0;
    start_i      = 1'b0;
  endtask

  task automatic err_case(input int w, input int bpp);
    @(negedge clk);
    set_req(32'h100, 32'h2000, w, 3, 4, 4, bpp);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R10 err pulse", err_o, 1);
    chk(pair_valid_o == 1'b0, "R10 no pair", pair_valid_o, 0);
    chk(busy_o == 1'b0, "R10 not busy", busy_o, 0);
    @(negedge clk);
    chk(err_o == 1'b0, "R10 err single", err_o, 0);
    chk(pair_valid_o == 1'b0, "R10 still idle", pair_valid_o, 0);
    chk(done_o == 1'b0, "R10 no done", done_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    pair_ready_i = 1'b0;
    set_req(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!pair_valid_o && !busy_o && !done_o && !err_o, "R1 in reset",
        {pair_valid_o, busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!pair_valid_o && !busy_o && !done_o && !err_o, "R1 after release",
        {pair_valid_o, busy_o, done_o, err_o}, 0);

    run_case(32'h0001_0000, 32'h0020_0000, 4, 3, 10, 5, 2, 0, 1'b0);
    run_case(32'h0003_0000, 32'h0040_0000, 9, 2, (320 - 9) / 2, (240 - 2) / 2, 2, 1, 1'b0);
    run_case(32'h0000_1000, 32'h0080_0000, 2, 4, 3, 7, 3, 2, 1'b1);
    run_case(32'h0000_0800, 32'h0010_0000, 6, 1, 0, 0, 1, 0, 1'b0);
    run_case(32'h0000_0400, 32'h0011_0000, 1, 3, 319, 239, 2, 1, 1'b0);
    run_case(32'h0000_0200, 32'h0012_0000, 8, 2, 21, 1, 4, 2, 1'b1);
    err_case(5, 1);
    err_case(3, 3);
    run_case(32'h0000_0100, 32'h0013_0000, 4, 0, 2, 2, 2, 0, 1'b0);
    run_case(32'h0000_0100, 32'h0013_0000, 0, 5, 2, 2, 2, 0, 1'b0);
    finish_run();
  end

endmodule